// File: doc/BRIEF.md
# Dual Shift-Register Output Driver

This block turns a 16-bit output word into the serial waveforms needed by two cascaded serial-in, parallel-out shift registers that have a separate storage latch, giving 16 output lines. A client presents a word with a one-cycle load strobe. The block shifts the word out on a data line and a shift clock, then pulses the storage clock so that all 16 outputs change together. A busy level and a one-cycle done pulse frame each transfer. Loads that arrive during a transfer are ignored.

After reset the block runs a fixed power-on sequence. It first holds the active-low clear line asserted for one phase. It then releases the clear and issues one storage clock pulse. This leaves the external outputs at zero before any word is accepted. A parameter sets how many system clocks each half of the shift clock lasts, and the storage pulse uses the same phase length.

The controller is a single state machine with seven states:
- `S_HOLD_CLR` is the reset state, in which the clear line is asserted.
- `S_RELEASE` holds the clear line released with the storage clock low.
- `S_INIT_PULSE` is the start-up storage pulse.
- `S_IDLE` waits for a load strobe.
- `S_BIT_LOW` is the low half of a shift clock period, in which the data line shows the current bit.
- `S_BIT_HIGH` is the high half of a shift clock period.
- `S_LATCH_PULSE` is the storage pulse that ends a transfer.

The transitions are as follows:
- On a phase tick, `S_HOLD_CLR` goes to `S_RELEASE`, which goes to `S_INIT_PULSE`, which goes to `S_IDLE`.
- `S_IDLE` goes to `S_BIT_LOW` when a load strobe arrives.
- On a phase tick, `S_BIT_LOW` goes to `S_BIT_HIGH`.
- On a phase tick, `S_BIT_HIGH` goes back to `S_BIT_LOW` while bits remain. After the last bit it goes to `S_LATCH_PULSE`.
- On a phase tick, `S_LATCH_PULSE` returns to `S_IDLE`.

Top module: `sipo_pair_driver`

## Requirements
- R1: While reset is held and in the first cycle after it, the clear, shift clock, storage clock and data outputs are all low, done is low and the latched-word output is zero.
- R2: After reset, the clear line is driven high before exactly one storage clock pulse. That pulse is issued with clear high and before any shift clock edge. Busy stays high until this sequence ends.
- R3: The two bytes of the word are exchanged before shifting. After a transfer, output k of the first device (the one fed by the data line) carries word bit 8+k, and output k of the second device carries word bit k, for k = 0..7.
- R4: Each transfer produces exactly 16 rising shift clock edges. The data line shows the most significant bit of the byte-swapped word first and changes only while the shift clock is low.
- R5: Every low and every high phase of the shift clock inside a transfer lasts exactly PHASE_CLKS system clocks. The storage clock pulse also lasts exactly PHASE_CLKS system clocks.
- R6: The storage clock stays low while bits are shifted. It rises once, after the 16th rising shift clock edge, and then returns low.
- R7: A load strobe that arrives while busy is high has no effect on the shifted bits or on the latched outputs.
- R8: Busy rises in the cycle after an accepted load strobe and stays high until the storage clock returns low. In that cycle busy drops and done is high for exactly one cycle.
- R9: The latched-word output holds the word of the last completed transfer. It changes only in the cycle in which done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | One-cycle request to send word_i |
| word_i | input | 16 | Output word to send |
| busy_o | output | 1 | High while the start-up sequence or a transfer runs |
| done_o | output | 1 | One-cycle pulse when the storage clock returns low |
| sdata_o | output | 1 | Serial data to the first device |
| sck_o | output | 1 | Shift clock; data is taken on its rising edge |
| rck_o | output | 1 | Storage (latch) clock |
| clr_n_o | output | 1 | Shift register clear, active low |
| latched_o | output | 16 | Word of the last completed transfer |

## Verification
The embedded assertions check the following on every cycle:
- the data line never moves while the shift clock is high;
- the storage clock is never high together with the shift clock, and never high while clear is asserted;
- done lasts a single cycle and coincides with busy low and a falling storage clock;
- the latched-word output moves only with done.

Only the bench scenarios can show the properties that need a model of the two external devices:
- the byte exchange and the resulting output pin mapping;
- the exact count of 16 shift edges;
- the phase widths;
- the single start-up pulse that clears the outputs;
- that loads issued mid-transfer and during start-up leave the outputs untouched.

// File: rtl/spd_pkg.sv
package spd_pkg;

    typedef enum logic [2:0] {
        S_HOLD_CLR,
        S_RELEASE,
        S_INIT_PULSE,
        S_IDLE,
        S_BIT_LOW,
        S_BIT_HIGH,
        S_LATCH_PULSE
    } spd_state_e;

endpackage

// File: rtl/spd_phase_timer.sv
module spd_phase_timer #(
    parameter int PHASE_CLKS = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic restart_i,
    output logic tick_o
);
    localparam int CW = (PHASE_CLKS > 1) ? $clog2(PHASE_CLKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(PHASE_CLKS - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = (cnt_q == LAST);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (restart_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    a_r5_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cnt_q <= LAST);

endmodule

// File: rtl/spd_shifter.sv
module spd_shifter #(
    parameter int DEV_W   = 8,
    parameter int NUM_DEV = 2
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic                       load_i,
    input  logic [DEV_W*NUM_DEV-1:0]   word_i,
    input  logic                       shift_i,
    output logic                       msb_o,
    output logic                       last_o
);
    localparam int WORD_W = DEV_W * NUM_DEV;
    localparam int BCW    = $clog2(WORD_W);
    localparam logic [BCW-1:0] LAST_BIT = BCW'(WORD_W - 1);

    logic [WORD_W-1:0] swapped;
    logic [WORD_W-1:0] sr_q;
    logic [BCW-1:0]    bcnt_q;

    // device order reversal: the slice for the device nearest the data pin
    // is shifted last, so it is placed at the low end of the stream
    for (genvar g = 0; g < NUM_DEV; g++) begin : g_reorder
        assign swapped[g*DEV_W +: DEV_W] = word_i[(NUM_DEV-1-g)*DEV_W +: DEV_W];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            sr_q   <= '0;
            bcnt_q <= '0;
        end else if (load_i) begin
            sr_q   <= swapped;
            bcnt_q <= '0;
        end else if (shift_i) begin
            sr_q   <= {sr_q[WORD_W-2:0], 1'b0};
            bcnt_q <= bcnt_q + 1'b1;
        end
    end

    assign msb_o  = sr_q[WORD_W-1];
    assign last_o = (bcnt_q == LAST_BIT);

    a_r4_no_shift_past_last: assert property (@(posedge clk_i) disable iff (!rst_ni)
        shift_i |-> !last_o);

endmodule

// File: rtl/sipo_pair_driver.sv
module sipo_pair_driver
    import spd_pkg::*;
#(
    parameter int DEV_W      = 8,
    parameter int NUM_DEV    = 2,
    parameter int PHASE_CLKS = 3
) (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     load_i,
    input  logic [DEV_W*NUM_DEV-1:0] word_i,
    output logic                     busy_o,
    output logic                     done_o,
    output logic                     sdata_o,
    output logic                     sck_o,
    output logic                     rck_o,
    output logic                     clr_n_o,
    output logic [DEV_W*NUM_DEV-1:0] latched_o
);
    localparam int WORD_W = DEV_W * NUM_DEV;

    spd_state_e        state_q, state_d;
    logic              tick, restart, accept, shift, bit_msb, bit_last;
    logic              done_q;
    logic [WORD_W-1:0] hold_q, latched_q;

    assign accept  = (state_q == S_IDLE) && load_i;
    assign restart = tick || (state_q == S_IDLE);
    assign shift   = (state_q == S_BIT_HIGH) && tick && !bit_last;

    spd_phase_timer #(.PHASE_CLKS(PHASE_CLKS)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .restart_i (restart),
        .tick_o    (tick)
    );

    spd_shifter #(.DEV_W(DEV_W), .NUM_DEV(NUM_DEV)) u_shifter (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .load_i  (accept),
        .word_i  (word_i),
        .shift_i (shift),
        .msb_o   (bit_msb),
        .last_o  (bit_last)
    );

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= S_HOLD_CLR;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_HOLD_CLR:    if (tick) state_d = S_RELEASE;
            S_RELEASE:     if (tick) state_d = S_INIT_PULSE;
            S_INIT_PULSE:  if (tick) state_d = S_IDLE;
            S_IDLE:        if (load_i) state_d = S_BIT_LOW;
            S_BIT_LOW:     if (tick) state_d = S_BIT_HIGH;
            S_BIT_HIGH:    if (tick) state_d = bit_last ? S_LATCH_PULSE : S_BIT_LOW;
            S_LATCH_PULSE: if (tick) state_d = S_IDLE;
            default:       state_d = S_HOLD_CLR;
        endcase
    end

    // outputs decoded from the state register
    always_comb begin
        sck_o   = 1'b0;
        rck_o   = 1'b0;
        sdata_o = 1'b0;
        clr_n_o = 1'b1;
        busy_o  = 1'b1;
        unique case (state_q)
            S_HOLD_CLR:    clr_n_o = 1'b0;
            S_RELEASE:     ;
            S_INIT_PULSE:  rck_o = 1'b1;
            S_IDLE:        busy_o = 1'b0;
            S_BIT_LOW:     sdata_o = bit_msb;
            S_BIT_HIGH: begin
                sdata_o = bit_msb;
                sck_o   = 1'b1;
            end
            S_LATCH_PULSE: rck_o = 1'b1;
            default:       clr_n_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_q    <= 1'b0;
            hold_q    <= '0;
            latched_q <= '0;
        end else begin
            done_q <= (state_q == S_LATCH_PULSE) && tick;
            if (accept) hold_q <= word_i;
            if ((state_q == S_LATCH_PULSE) && tick) latched_q <= hold_q;
        end
    end

    assign done_o    = done_q;
    assign latched_o = latched_q;

    a_r4_data_steady_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sck_o && $past(sck_o)) |-> $stable(sdata_o));

    a_r6_no_latch_while_shifting: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sck_o |-> !rck_o);

    a_r2_latch_with_clear_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rck_o |-> clr_n_o);

    a_r8_done_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    a_r8_done_at_latch_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (!busy_o && !rck_o && $past(rck_o)));

    a_r7_busy_load_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && load_i) |=> $stable(hold_q));

    a_r9_latched_moves_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !done_o |-> $stable(latched_o));

endmodule

// File: tb/sipo_pair_driver_tb.sv
module sipo_pair_driver_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PHASE      = 3;
    localparam int WDOG_LIMIT = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load = 1'b0;
    logic [15:0] word = '0;
    logic        busy, done, sdata, sck, rck, clr_n;
    logic [15:0] latched;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    sipo_pair_driver #(.DEV_W(8), .NUM_DEV(2), .PHASE_CLKS(PHASE)) u_dut (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .load_i    (load),
        .word_i    (word),
        .busy_o    (busy),
        .done_o    (done),
        .sdata_o   (sdata),
        .sck_o     (sck),
        .rck_o     (rck),
        .clr_n_o   (clr_n),
        .latched_o (latched)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // model of the two cascaded devices, sampled away from the active edge
    logic [15:0] sr16 = '0;
    logic [15:0] pins = 16'hDEAD;
    logic prev_sck = 1'b0, prev_rck = 1'b0, prev_sdata = 1'b0;
    int sck_rises = 0, rck_rises = 0;
    int sck_run = 0, rck_run = 0;
    int width_err = 0, data_err = 0, clr_err = 0;
    bit fall_seen = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (!clr_n) sr16 = '0;
            if (sck && prev_sck && (sdata != prev_sdata)) data_err++;
            if (sck != prev_sck) begin
                if (sck) begin
                    sr16 = {sr16[14:0], sdata};
                    sck_rises++;
                    if (fall_seen && sck_run != PHASE) width_err++;
                end else begin
                    if (sck_run != PHASE) width_err++;
                    fall_seen = 1'b1;
                end
                sck_run = 1;
            end else begin
                sck_run++;
            end
            if (rck != prev_rck) begin
                if (rck) begin
                    pins = sr16;
                    rck_rises++;
                    if (!clr_n) clr_err++;
                end else if (rck_run != PHASE) begin
                    width_err++;
                end
                rck_run = 1;
            end else begin
                rck_run++;
            end
            prev_sck   = sck;
            prev_rck   = rck;
            prev_sdata = sdata;
        end
    end

    function automatic logic [15:0] exp_pins(input logic [15:0] w);
        return {w[7:0], w[15:8]};
    endfunction

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=<%0d", WDOG_LIMIT, WDOG_LIMIT);
        finish_run();
    end

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    // one transfer; optionally a second load is issued mid-transfer
    task automatic xfer(input logic [15:0] w, input bit poke, input logic [15:0] other);
        int s0, r0, w0, d0, cyc;
        bit busy_ok;
        wait_idle();
        s0 = sck_rises; r0 = rck_rises; w0 = width_err; d0 = data_err;
        fall_seen = 1'b0;
        load = 1'b1; word = w;
        @(negedge clk);
        load = 1'b0; word = ~w;
        busy_ok = 1'b1;
        cyc = 0;
        while (!done && cyc < 200) begin
            if (!busy) busy_ok = 1'b0;
            if (poke && cyc == 7) begin
                load = 1'b1; word = other;
            end else begin
                load = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        load = 1'b0;
        check(busy_ok, "R8 busy held through transfer", {31'd0, busy_ok}, 1);
        check(done && !busy && !rck, "R8 done with busy low and latch low",
              {29'd0, done, busy, rck}, 32'h4);
        check(sck_rises - s0 == 16, "R4 shift edge count", sck_rises - s0, 16);
        check(rck_rises - r0 == 1, "R6 one latch pulse", rck_rises - r0, 1);
        check(pins == exp_pins(w), poke ? "R7 mid-transfer load ignored" : "R3 pin mapping",
              {16'd0, pins}, {16'd0, exp_pins(w)});
        check(latched == w, "R9 latched word", {16'd0, latched}, {16'd0, w});
        check(width_err == w0, "R5 phase widths", width_err - w0, 0);
        check(data_err == d0, "R4 data steady while clock high", data_err - d0, 0);
        @(negedge clk);
        check(!done, "R8 done one cycle", {31'd0, done}, 0);
        check(latched == w, "R9 latched holds", {16'd0, latched}, {16'd0, w});
    endtask

    initial begin
        logic [15:0] directed [5];
        void'($urandom(32'h5EED1234));
        directed[0] = 16'h0000; directed[1] = 16'hFFFF; directed[2] = 16'h8001;
        directed[3] = 16'h00FF; directed[4] = 16'hA55A;

        repeat (3) @(negedge clk);
        check(!sck && !rck && !sdata && !clr_n && !done && latched == 0,
              "R1 outputs during reset", {26'd0, sck, rck, sdata, clr_n, done, 1'b0}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sck && !rck && !sdata && !clr_n && !done && latched == 0,
              "R1 outputs after reset", {27'd0, sck, rck, sdata, clr_n, done}, 0);
        check(busy, "R2 busy during start-up", {31'd0, busy}, 1);
        // load during start-up must be ignored
        load = 1'b1; word = 16'h1234;
        @(negedge clk);
        load = 1'b0;
        wait_idle();
        check(rck_rises == 1, "R2 single start-up latch pulse", rck_rises, 1);
        check(clr_err == 0, "R2 latch pulse with clear released", clr_err, 0);
        check(sck_rises == 0, "R2 no shifting during start-up", sck_rises, 0);
        check(pins == 16'h0000, "R2 outputs cleared at start-up", {16'd0, pins}, 0);
        check(latched == 16'h0000, "R7 start-up load ignored", {16'd0, latched}, 0);
        repeat (4) @(negedge clk);
        check(latched == 16'h0000 && !busy, "R7 no transfer after start-up load",
              {15'd0, busy, latched}, 0);

        for (int i = 0; i < 5; i++) xfer(directed[i], 1'b0, 16'h0);
        xfer(16'h3C96, 1'b1, 16'hFFFF);
        for (int i = 0; i < 20; i++) begin
            logic [15:0] rw, ro;
            rw = 16'($urandom);
            ro = ~rw;
            xfer(rw, (i % 3) == 0, ro);
        end
        check(width_err == 0 && data_err == 0 && clr_err == 0, "R5 totals clean",
              width_err + data_err + clr_err, 0);
        finish_run();
    end

endmodule